// File: doc/BRIEF.md
# Two-Slot PCM Frame Transmitter

This block drives a PCM serial output as the bus master. An external divider supplies a bit-rate tick. On each tick the block moves to the next bit period of a frame whose length is programmable. It drives a frame sync, a serial data bit, and a one-cycle strobe that marks the cycle in which both of those outputs take their new values. A frame holds at most two channel words. Each word starts at its own programmable bit offset, counted from the frame start. Every other bit period in the frame carries zero, so long frames of up to 1024 bit periods can carry two words at arbitrary places.

Each channel offers its samples through a valid/ready pair, and a word is taken only on the tick that opens a frame. The block supports two framing styles. In pulse style the sync is high for exactly the first bit period, and data may start in that same period. In level style the sync is a half-frame level, and only its rising edge marks the frame start. All configuration inputs are captured at the frame start, so software may change them at any time without tearing a frame.

Top module: `pcm_slot_tx`

## Requirements
- R1: A frame lasts cfg_len_m1_i+1 bit periods (one per accepted tick), with lengths up to 1024. The first tick after reset, and the tick that follows the last bit period of a frame, both open a new frame at bit position 0.
- R2: With cfg_mode_i=0 (pulse style), fsync_o is 1 during bit position 0 only and 0 at every other position.
- R3: With cfg_mode_i=1 (level style), fsync_o is 1 for positions 0 through ceil(L/2)-1 and 0 for the remaining positions, where L is the frame length.
- R4: The word width W is cfg_ch_wm1_i+1 (1 to 32). Channel k sends the low W bits of its latched sample at positions cfg_chk_pos_i through cfg_chk_pos_i+W-1. The MSB goes first, so sample bit W-1 is sent at the start position.
- R5: At every bit position that neither channel window covers, sdata_o is 0.
- R6: Where the two windows overlap, the bits of channel 0 are sent. A window that runs past the last position of the frame is cut off there.
- R7: ch0_ready_o and ch1_ready_o are 1 only during a tick that opens a frame, and the sample on each channel's data input is latched at that tick.
- R8: If a channel's valid input is 0 at a frame-opening tick, that channel sends zeros for the whole frame and underrun_o is set. underrun_o then stays 1 until reset.
- R9: Changes to any configuration input or sample data input after the frame-opening tick have no effect on the frame in progress.
- R10: For a tick sampled at clock edge k, fsync_o, sdata_o and bclk_stb_o=1 appear after edge k+1. fsync_o and sdata_o change only on edges that raise bclk_stb_o for one cycle.
- R11: While reset is asserted, and after it is released until the first tick, fsync_o, sdata_o, bclk_stb_o, underrun_o and both ready outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick_i | input | 1 | Bit-rate tick from an external divider |
| cfg_len_m1_i | input | CNT_W | Frame length minus one, in bit periods |
| cfg_mode_i | input | 1 | Sync style: 0 = single-bit pulse, 1 = half-frame level |
| cfg_ch0_pos_i | input | CNT_W | First bit position of channel 0 |
| cfg_ch1_pos_i | input | CNT_W | First bit position of channel 1 |
| cfg_ch_wm1_i | input | WSEL_W | Channel word width minus one |
| ch0_data_i | input | DATA_W | Channel 0 sample |
| ch0_valid_i | input | 1 | Channel 0 sample present |
| ch0_ready_o | output | 1 | Channel 0 sample taken this cycle |
| ch1_data_i | input | DATA_W | Channel 1 sample |
| ch1_valid_i | input | 1 | Channel 1 sample present |
| ch1_ready_o | output | 1 | Channel 1 sample taken this cycle |
| fsync_o | output | 1 | Frame sync |
| sdata_o | output | 1 | Serial data |
| bclk_stb_o | output | 1 | Marks the cycle in which a new bit period begins |
| underrun_o | output | 1 | Sticky flag: a frame opened without a sample |

## Verification
The assertions check on every cycle that the outputs change only together with the strobe and that each strobe follows a tick by two edges. They also check that the ready outputs appear only during a tick, and that the underrun flag is set when a frame opens with a missing sample and then never clears. Only the bench scenarios can show the bit placement inside a frame. This covers the MSB-first order, zero fill over a 512-bit frame, channel 0 winning an overlap, truncation at the frame end, the two sync shapes, and the fact that mid-frame configuration changes are ignored. To show these, the bench compares every strobed bit against an expected value that it computes on its own.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
  typedef enum logic {
    FS_PULSE = 1'b0,
    FS_LEVEL = 1'b1
  } fs_mode_e;
endpackage

// File: rtl/pcm_frame_ctr.sv
// Bit position counter and per-frame configuration shadow.
module pcm_frame_ctr
  import pcm_slot_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int WSEL_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_i,
  input  logic [CNT_W-1:0]        cfg_len_m1_i,
  input  fs_mode_e                cfg_mode_i,
  input  logic [1:0][CNT_W-1:0]   cfg_pos_i,
  input  logic [WSEL_W-1:0]       cfg_wm1_i,
  output logic                    start_o,
  output logic                    adv_o,
  output logic [CNT_W-1:0]        pos_o,
  output logic [CNT_W-1:0]        len_m1_o,
  output fs_mode_e                mode_o,
  output logic [1:0][CNT_W-1:0]   ch_pos_o,
  output logic [WSEL_W-1:0]       wm1_o
);

  logic                  run_q, run_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [CNT_W-1:0]      len_q, len_d;
  fs_mode_e              mode_q, mode_d;
  logic [1:0][CNT_W-1:0] cpos_q, cpos_d;
  logic [WSEL_W-1:0]     wm1_q, wm1_d;
  logic                  adv_q;
  logic                  at_end;

  assign at_end  = (cnt_q == len_q);
  assign start_o = tick_i && (!run_q || at_end);

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    len_d  = len_q;
    mode_d = mode_q;
    cpos_d = cpos_q;
    wm1_d  = wm1_q;
    if (start_o) begin
      run_d  = 1'b1;
      cnt_d  = '0;
      len_d  = cfg_len_m1_i;
      mode_d = cfg_mode_i;
      cpos_d = cfg_pos_i;
      wm1_d  = cfg_wm1_i;
    end else if (tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
      mode_q <= FS_PULSE;
      cpos_q <= '0;
      wm1_q  <= '0;
      adv_q  <= 1'b0;
    end else begin
      adv_q <= tick_i;
      if (tick_i) begin
        run_q  <= run_d;
        cnt_q  <= cnt_d;
        len_q  <= len_d;
        mode_q <= mode_d;
        cpos_q <= cpos_d;
        wm1_q  <= wm1_d;
      end
    end
  end

  assign adv_o    = adv_q;
  assign pos_o    = cnt_q;
  assign len_m1_o = len_q;
  assign mode_o   = mode_q;
  assign ch_pos_o = cpos_q;
  assign wm1_o    = wm1_q;

endmodule

// File: rtl/pcm_word_hold.sv
// Holds one channel's sample for the frame; zero when none was offered.
module pcm_word_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] word_o,
  output logic              miss_o
);

  logic [DATA_W-1:0] word_q, word_d;

  assign miss_o = load_i && !valid_i;

  always_comb begin
    word_d = word_q;
    if (load_i) word_d = valid_i ? data_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else if (load_i) word_q <= word_d;
  end

  assign word_o = word_q;

endmodule

// File: rtl/pcm_bit_gen.sv
// Output stage: sync shape, window select with channel 0 priority.
module pcm_bit_gen
  import pcm_slot_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int DATA_W = 32,
  parameter int WSEL_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv_i,
  input  logic [CNT_W-1:0]        pos_i,
  input  logic [CNT_W-1:0]        len_m1_i,
  input  fs_mode_e                mode_i,
  input  logic [1:0][CNT_W-1:0]   ch_pos_i,
  input  logic [WSEL_W-1:0]       wm1_i,
  input  logic [1:0][DATA_W-1:0]  ch_word_i,
  output logic                    fsync_o,
  output logic                    sdata_o,
  output logic                    stb_o
);

  localparam int HW = CNT_W + 1;

  logic [1:0] hit;
  logic [1:0] bitv;
  logic [HW-1:0] half;
  logic fs_d, sd_d;
  logic fs_q, sd_q, stb_q;

  for (genvar g = 0; g < 2; g++) begin : g_win
    logic [CNT_W-1:0]  offs;
    logic [WSEL_W-1:0] idx;
    assign offs   = pos_i - ch_pos_i[g];
    assign hit[g] = (pos_i >= ch_pos_i[g]) && (offs <= CNT_W'(wm1_i));
    assign idx    = wm1_i - offs[WSEL_W-1:0];
    assign bitv[g] = ch_word_i[g][idx];
  end

  assign half = ({1'b0, len_m1_i} + HW'(2)) >> 1;

  always_comb begin
    if (mode_i == FS_PULSE) fs_d = (pos_i == '0);
    else                    fs_d = ({1'b0, pos_i} < half);
    if (hit[0])      sd_d = bitv[0];
    else if (hit[1]) sd_d = bitv[1];
    else             sd_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q  <= 1'b0;
      sd_q  <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= adv_i;
      if (adv_i) begin
        fs_q <= fs_d;
        sd_q <= sd_d;
      end
    end
  end

  assign fsync_o = fs_q;
  assign sdata_o = sd_q;
  assign stb_o   = stb_q;

endmodule

// File: rtl/pcm_slot_tx.sv
module pcm_slot_tx
  import pcm_slot_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int DATA_W = 32,
  localparam int WSEL_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick_i,
  input  logic [CNT_W-1:0]  cfg_len_m1_i,
  input  logic              cfg_mode_i,
  input  logic [CNT_W-1:0]  cfg_ch0_pos_i,
  input  logic [CNT_W-1:0]  cfg_ch1_pos_i,
  input  logic [WSEL_W-1:0] cfg_ch_wm1_i,
  input  logic [DATA_W-1:0] ch0_data_i,
  input  logic              ch0_valid_i,
  output logic              ch0_ready_o,
  input  logic [DATA_W-1:0] ch1_data_i,
  input  logic              ch1_valid_i,
  output logic              ch1_ready_o,
  output logic              fsync_o,
  output logic              sdata_o,
  output logic              bclk_stb_o,
  output logic              underrun_o
);

  logic                   frm_start, frm_adv;
  logic [CNT_W-1:0]       frm_pos, frm_len;
  fs_mode_e               frm_mode;
  logic [1:0][CNT_W-1:0]  frm_cpos;
  logic [WSEL_W-1:0]      frm_wm1;
  logic [1:0][DATA_W-1:0] in_data, words;
  logic [1:0]             in_valid, miss;
  logic                   urun_q, urun_d;

  assign in_data  = {ch1_data_i, ch0_data_i};
  assign in_valid = {ch1_valid_i, ch0_valid_i};

  pcm_frame_ctr #(.CNT_W(CNT_W), .WSEL_W(WSEL_W)) u_ctr (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (bit_tick_i),
    .cfg_len_m1_i (cfg_len_m1_i),
    .cfg_mode_i   (fs_mode_e'(cfg_mode_i)),
    .cfg_pos_i    ({cfg_ch1_pos_i, cfg_ch0_pos_i}),
    .cfg_wm1_i    (cfg_ch_wm1_i),
    .start_o      (frm_start),
    .adv_o        (frm_adv),
    .pos_o        (frm_pos),
    .len_m1_o     (frm_len),
    .mode_o       (frm_mode),
    .ch_pos_o     (frm_cpos),
    .wm1_o        (frm_wm1)
  );

  for (genvar g = 0; g < 2; g++) begin : g_ch
    pcm_word_hold #(.DATA_W(DATA_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (frm_start),
      .valid_i (in_valid[g]),
      .data_i  (in_data[g]),
      .word_o  (words[g]),
      .miss_o  (miss[g])
    );
  end

  pcm_bit_gen #(.CNT_W(CNT_W), .DATA_W(DATA_W), .WSEL_W(WSEL_W)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv_i     (frm_adv),
    .pos_i     (frm_pos),
    .len_m1_i  (frm_len),
    .mode_i    (frm_mode),
    .ch_pos_i  (frm_cpos),
    .wm1_i     (frm_wm1),
    .ch_word_i (words),
    .fsync_o   (fsync_o),
    .sdata_o   (sdata_o),
    .stb_o     (bclk_stb_o)
  );

  assign urun_d = urun_q | (|miss);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) urun_q <= 1'b0;
    else        urun_q <= urun_d;
  end

  assign underrun_o  = urun_q;
  assign ch0_ready_o = frm_start;
  assign ch1_ready_o = frm_start;

endmodule

// File: rtl/pcm_slot_tx_chk.sv
module pcm_slot_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick_i,
  input logic ch0_valid_i,
  input logic ch0_ready_o,
  input logic ch1_valid_i,
  input logic ch1_ready_o,
  input logic fsync_o,
  input logic sdata_o,
  input logic bclk_stb_o,
  input logic underrun_o
);

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_stb_o |-> ($stable(fsync_o) && $stable(sdata_o))); // R10

  AST_STB_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_stb_o |-> $past(bit_tick_i, 2)); // R10

  AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (ch0_ready_o || ch1_ready_o) |-> bit_tick_i); // R7

  AST_UNDERRUN_CH0: assert property (@(posedge clk) disable iff (!rst_n)
    (ch0_ready_o && !ch0_valid_i) |=> underrun_o); // R8

  AST_UNDERRUN_CH1: assert property (@(posedge clk) disable iff (!rst_n)
    (ch1_ready_o && !ch1_valid_i) |=> underrun_o); // R8

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |=> underrun_o); // R8

endmodule

bind pcm_slot_tx pcm_slot_tx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_tick_i  (bit_tick_i),
  .ch0_valid_i (ch0_valid_i),
  .ch0_ready_o (ch0_ready_o),
  .ch1_valid_i (ch1_valid_i),
  .ch1_ready_o (ch1_ready_o),
  .fsync_o     (fsync_o),
  .sdata_o     (sdata_o),
  .bclk_stb_o  (bclk_stb_o),
  .underrun_o  (underrun_o)
);

// File: tb/tb_pcm_slot_tx.sv
`timescale 1ns/1ps
module tb_pcm_slot_tx;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_tick_i;
  logic [9:0]  cfg_len_m1_i, cfg_ch0_pos_i, cfg_ch1_pos_i;
  logic        cfg_mode_i;
  logic [4:0]  cfg_ch_wm1_i;
  logic [31:0] ch0_data_i, ch1_data_i;
  logic        ch0_valid_i, ch1_valid_i;
  logic        ch0_ready_o, ch1_ready_o;
  logic        fsync_o, sdata_o, bclk_stb_o, underrun_o;

  int n_chk = 0;
  int n_err = 0;

  bit    q_fs[$];
  bit    q_sd[$];
  string q_tfs[$];
  string q_tsd[$];

  always #2 clk = ~clk;

  pcm_slot_tx dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // Monitor: pop one expected bit per strobe.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && bclk_stb_o === 1'b1) begin
      if (q_fs.size() == 0) begin
        chk(1'b0, "R10", "strobe without tick", 1, 0);
      end else begin
        bit efs, esd;
        string tfs, tsd;
        efs = q_fs.pop_front(); esd = q_sd.pop_front();
        tfs = q_tfs.pop_front(); tsd = q_tsd.pop_front();
        chk(fsync_o === efs, tfs, "fsync", int'(fsync_o), int'(efs));
        chk(sdata_o === esd, tsd, "sdata", int'(sdata_o), int'(esd));
      end
    end
  end

  // Driver: one frame, pushing the independently computed bit stream.
  task automatic frame(input int len, input bit md, input int p0, input int p1,
                       input int w, input logic [31:0] d0, input logic [31:0] d1,
                       input bit v0, input bit v1, input bit scram, input string tag);
    logic [31:0] e0, e1;
    e0 = v0 ? d0 : 32'h0;
    e1 = v1 ? d1 : 32'h0;
    for (int p = 0; p < len; p++) begin
      bit fs, sd, inw;
      @(negedge clk);
      if (p == 0) begin
        cfg_len_m1_i  = 10'(len - 1);
        cfg_mode_i    = md;
        cfg_ch0_pos_i = 10'(p0);
        cfg_ch1_pos_i = 10'(p1);
        cfg_ch_wm1_i  = 5'(w - 1);
        ch0_data_i    = d0;
        ch1_data_i    = d1;
        ch0_valid_i   = v0;
        ch1_valid_i   = v1;
      end
      if (p == 1 && scram) begin
        // R9: disturb everything mid-frame
        cfg_len_m1_i  = 10'd19;
        cfg_mode_i    = ~md;
        cfg_ch0_pos_i = 10'(p1);
        cfg_ch1_pos_i = 10'(p0);
        cfg_ch_wm1_i  = 5'd7;
        ch0_data_i    = ~d0;
        ch1_data_i    = ~d1;
      end
      bit_tick_i = 1'b1;
      #1;
      if (p == 0) begin
        chk(ch0_ready_o === 1'b1, "R7", "ch0 ready at start", int'(ch0_ready_o), 1);
        chk(ch1_ready_o === 1'b1, "R7", "ch1 ready at start", int'(ch1_ready_o), 1);
      end
      if (p == 1)
        chk(ch0_ready_o === 1'b0 && ch1_ready_o === 1'b0, "R7", "ready mid-frame",
            int'(ch0_ready_o | ch1_ready_o), 0);
      fs  = md ? (p < (len + 1) / 2) : (p == 0);
      inw = 1'b1;
      if (p >= p0 && p < p0 + w)      sd = e0[w - 1 - (p - p0)];
      else if (p >= p1 && p < p1 + w) sd = e1[w - 1 - (p - p1)];
      else begin sd = 1'b0; inw = 1'b0; end
      q_fs.push_back(fs);
      q_sd.push_back(sd);
      q_tfs.push_back(md ? "R3" : "R2");
      q_tsd.push_back(inw ? tag : "R5");
      @(negedge clk);
      bit_tick_i = 1'b0;
      if (p == 0) begin ch0_valid_i = 1'b0; ch1_valid_i = 1'b0; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R1", "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bit_tick_i = 1'b0;
    cfg_len_m1_i = '0; cfg_mode_i = 1'b0; cfg_ch0_pos_i = '0; cfg_ch1_pos_i = '0;
    cfg_ch_wm1_i = '0; ch0_data_i = '0; ch1_data_i = '0;
    ch0_valid_i = 1'b0; ch1_valid_i = 1'b0;
    repeat (4) @(negedge clk);
    chk({fsync_o, sdata_o, bclk_stb_o, underrun_o} === 4'b0, "R11", "outputs in reset",
        int'({fsync_o, sdata_o, bclk_stb_o, underrun_o}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({fsync_o, sdata_o, bclk_stb_o, underrun_o, ch0_ready_o} === 5'b0, "R11",
        "outputs idle after reset",
        int'({fsync_o, sdata_o, bclk_stb_o, underrun_o, ch0_ready_o}), 0);

    frame(64,  1'b0, 0,   32,  32, 32'hA5C3_0F1E, 32'h1234_5678, 1, 1, 0, "R4");
    frame(64,  1'b1, 1,   33,  16, 32'h0000_BEEF, 32'h0000_CAFE, 1, 1, 0, "R4");
    frame(512, 1'b0, 100, 300, 32, 32'hF00D_D00F, 32'h8000_0001, 1, 1, 0, "R1");
    frame(40,  1'b1, 10,  20,  24, 32'h00FF_00FF, 32'h00AA_AA55, 1, 1, 0, "R6");
    frame(32,  1'b0, 4,   20,  32, 32'h6B1D_93C4, 32'hFFFF_FFFF, 1, 1, 0, "R6");
    frame(48,  1'b0, 0,   24,  24, 32'h0012_3456, 32'h00FE_DCBA, 1, 1, 1, "R9");
    chk(underrun_o === 1'b0, "R8", "no underrun yet", int'(underrun_o), 0);
    frame(32,  1'b0, 0,   16,  16, 32'h0000_9A9A, 32'h0000_FFFF, 1, 0, 0, "R8");
    chk(underrun_o === 1'b1, "R8", "underrun set", int'(underrun_o), 1);
    frame(33,  1'b1, 2,   17,  16, 32'h0000_3C3C, 32'h0000_8001, 1, 1, 0, "R4");
    chk(underrun_o === 1'b1, "R8", "underrun sticky", int'(underrun_o), 1);

    repeat (8) @(negedge clk);
    chk(q_fs.size() == 0, "R1", "bits left unsent", q_fs.size(), 0);
    chk(bclk_stb_o === 1'b0, "R10", "strobe idle", int'(bclk_stb_o), 0);
    finish_run();
  end

endmodule